// File: doc/BRIEF.md
# Masked Interrupt Controller with Vector Encoding

This block gathers thirty level-sensitive interrupt lines and two non-maskable lines into a pair of requests for a processor core. Each interrupt line is copied into a raw pending register every clock. That register is ANDed with a software-written enable mask to give a masked pending value. A hard-interrupt request is raised whenever the masked value is non-zero, and an 8-bit vector number comes with it. If exactly one masked line is active, the vector is a fixed base plus one plus that line's bit index. If several are active, a shared "multiple pending" code is given instead, and software must read the masked register to decide which line to serve.

The two non-maskable lines drive their own status register and a separate request that the mask never affects. A single fatal-exception input is not supported. It only sets a sticky flag, which reset alone clears. Software reaches the state through a 32-bit port addressed by word index. Only the mask word can be written. Any other write, and any read above the last defined word, gives a one-cycle error strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the mask, raw pending, masked pending, non-maskable status and fault status all read zero, and hard_req, hard_vec, nmi_req, fault_flag and bus_err are all zero.
- R2: Word index 1 reads the raw pending register. Bit k equals the level of irq_i[k] one clock earlier, and upper bits read zero.
- R3: Word index 0 is the enable mask. A write stores bus_wdata[29:0], and a read returns that value with bits 31:30 as zero.
- R4: Word index 2 reads the masked pending value, which equals raw pending AND mask.
- R5: When exactly one masked bit k is set, hard_vec = 0x31 + k and hard_req = 1.
- R6: When two or more masked bits are set, hard_vec = 0x30 and hard_req = 1.
- R7: When the masked value is zero, hard_vec = 0 and hard_req = 0.
- R8: Word index 3 reads the non-maskable status, where bit j follows nmi_i[j]. nmi_req is 1 when either bit is set, and the mask has no effect on either.
- R9: A high fault_i sets bit 0 of word index 4 and fault_flag. Both stay set until reset.
- R10: A read of word index 5, 6 or 7 returns zero, and a write to any index other than 0 changes no state. Both raise bus_err for exactly one cycle.
- R11: hard_req, hard_vec, nmi_req and all status words update on the first clock edge after an input change or mask write. bus_rdata and bus_err are valid in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 30 | Level-sensitive interrupt lines |
| nmi_i | input | 2 | Non-maskable interrupt lines |
| fault_i | input | 1 | Unsupported fatal-exception input |
| bus_addr | input | 3 | Word index of the register access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_err | output | 1 | One-cycle illegal-access strobe |
| hard_req | output | 1 | Maskable interrupt request |
| hard_vec | output | 8 | Encoded vector number |
| nmi_req | output | 1 | Non-maskable interrupt request |
| fault_flag | output | 1 | Sticky unsupported-exception flag |

## Verification
On every cycle, the assertions check several invariants. The masked register must stay equal to raw pending AND mask. The vector must fall in the range that matches the masked population count, and the request must agree with the vector. The non-maskable request must agree with its status, and the fault flag must never clear. Other behaviours need the bench's scenarios. These are the exact vector for each of the thirty single-line positions and for each single mask bit, the multiple-pending code across a sweep of bit pairs, the one-clock latency, and the rejection of illegal writes with the mask left unchanged.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int WORD_W = 32;
    localparam int VEC_W  = 8;
    localparam int IDX_W  = 3;
    localparam logic [VEC_W-1:0] VEC_MULTI = 8'h30;

    typedef enum logic [IDX_W-1:0] {
        IDX_MASK   = 3'd0,
        IDX_RAW    = 3'd1,
        IDX_MASKED = 3'd2,
        IDX_NMI    = 3'd3,
        IDX_FAULT  = 3'd4
    } reg_idx_e;

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_FAULT;
endpackage

// File: rtl/irqv_vec_enc.sv
module irqv_vec_enc
    import irqv_pkg::*;
#(
    parameter int N = 30
) (
    input  logic [N-1:0]     bits_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             any_o
);
    logic             multi;
    logic [VEC_W-1:0] idx;

    always_comb begin
        any_o = |bits_i;
        multi = (bits_i & (bits_i - N'(1))) != '0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (bits_i[k]) idx = VEC_W'(k);
        end
        if (!any_o)     vec_o = '0;
        else if (multi) vec_o = VEC_MULTI;
        else            vec_o = VEC_MULTI + VEC_W'(1) + idx;
    end
endmodule

// File: rtl/irqv_rd_mux.sv
module irqv_rd_mux
    import irqv_pkg::*;
#(
    parameter int N = 30,
    parameter int M = 2
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [N-1:0]      mask_i,
    input  logic [N-1:0]      raw_i,
    input  logic [N-1:0]      masked_i,
    input  logic [M-1:0]      nmi_i,
    input  logic              fault_i,
    output logic [WORD_W-1:0] data_o,
    output logic              legal_o
);
    always_comb begin
        legal_o = idx_i <= IDX_LAST;
        case (idx_i)
            IDX_MASK:   data_o = WORD_W'(mask_i);
            IDX_RAW:    data_o = WORD_W'(raw_i);
            IDX_MASKED: data_o = WORD_W'(masked_i);
            IDX_NMI:    data_o = WORD_W'(nmi_i);
            IDX_FAULT:  data_o = WORD_W'(fault_i);
            default:    data_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NUM_IRQ = 30,
    parameter int NUM_NMI = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_i,
    input  logic [NUM_NMI-1:0]   nmi_i,
    input  logic                 fault_i,
    input  logic [IDX_W-1:0]     bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 bus_err,
    output logic                 hard_req,
    output logic [VEC_W-1:0]     hard_vec,
    output logic                 nmi_req,
    output logic                 fault_flag
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] mask;
        logic [NUM_IRQ-1:0] raw;
        logic [NUM_IRQ-1:0] masked;
        logic [NUM_NMI-1:0] nmi;
        logic               fault;
        logic [VEC_W-1:0]   vec;
        logic               req;
        logic               nmi_req;
        logic [WORD_W-1:0]  rdata;
        logic               err;
    } state_t;

    state_t s_d, s_q;

    logic               wr_hit;
    logic [NUM_IRQ-1:0] mask_nxt;
    logic [NUM_IRQ-1:0] masked_nxt;
    logic [VEC_W-1:0]   enc_vec;
    logic               enc_any;
    logic [WORD_W-1:0]  rd_data;
    logic               rd_legal;

    assign wr_hit     = bus_wr && (bus_addr == IDX_MASK);
    assign mask_nxt   = wr_hit ? bus_wdata[NUM_IRQ-1:0] : s_q.mask;
    assign masked_nxt = irq_i & mask_nxt;

    irqv_vec_enc #(.N(NUM_IRQ)) enc_i (
        .bits_i (masked_nxt),
        .vec_o  (enc_vec),
        .any_o  (enc_any)
    );

    irqv_rd_mux #(.N(NUM_IRQ), .M(NUM_NMI)) mux_i (
        .idx_i    (bus_addr),
        .mask_i   (s_q.mask),
        .raw_i    (s_q.raw),
        .masked_i (s_q.masked),
        .nmi_i    (s_q.nmi),
        .fault_i  (s_q.fault),
        .data_o   (rd_data),
        .legal_o  (rd_legal)
    );

    always_comb begin
        s_d         = s_q;
        s_d.mask    = mask_nxt;
        s_d.raw     = irq_i;
        s_d.masked  = masked_nxt;
        s_d.nmi     = nmi_i;
        s_d.fault   = s_q.fault | fault_i;
        s_d.vec     = enc_vec;
        s_d.req     = enc_any;
        s_d.nmi_req = |nmi_i;
        s_d.rdata   = (bus_rd && rd_legal) ? rd_data : '0;
        s_d.err     = (bus_wr && !wr_hit) || (bus_rd && !rd_legal);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata  = s_q.rdata;
    assign bus_err    = s_q.err;
    assign hard_req   = s_q.req;
    assign hard_vec   = s_q.vec;
    assign nmi_req    = s_q.nmi_req;
    assign fault_flag = s_q.fault;

    p_raw_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> s_q.raw == $past(irq_i));
    p_masked_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.masked == (s_q.raw & s_q.mask));
    p_single_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(s_q.masked) == 1) |-> (hard_req && hard_vec > VEC_MULTI
                                           && hard_vec <= VEC_MULTI + VEC_W'(NUM_IRQ)));
    p_multi_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(s_q.masked) > 1) |-> (hard_req && hard_vec == VEC_MULTI));
    p_idle_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_req == 1'b0) |-> (hard_vec == '0));
    p_nmi_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req == (s_q.nmi != '0));
    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |=> fault_flag);
    p_bad_write_keeps_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != IDX_MASK) |=> (bus_err && s_q.mask == $past(s_q.mask)));
    p_bad_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr > IDX_LAST) |=> (bus_err && bus_rdata == '0));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0] irq_i;
    logic [1:0]  nmi_i;
    logic        fault_i;
    logic [2:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_err, hard_req, nmi_req, fault_flag;
    logic [7:0]  hard_vec;

    int total = 0;
    int failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i), .fault_i(fault_i),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .hard_req(hard_req),
        .hard_vec(hard_vec), .nmi_req(nmi_req), .fault_flag(fault_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d, output logic e);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        d = bus_rdata; e = bus_err;
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v, output logic e);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        tick();
        e = bus_err;
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    function automatic logic [7:0] exp_vec(input logic [N-1:0] m);
        int c = $countones(m);
        if (c == 0) return 8'h00;
        if (c > 1)  return 8'h30;
        for (int k = 0; k < N; k++) if (m[k]) return 8'h31 + 8'(k);
        return 8'h00;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; failed++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        e;
        logic [N-1:0] m;
        irq_i = '0; nmi_i = '0; fault_i = 1'b0;
        bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 hard_req", 32'(hard_req), 0);
        check("R1 hard_vec", 32'(hard_vec), 0);
        check("R1 nmi_req", 32'(nmi_req), 0);
        check("R1 fault_flag", 32'(fault_flag), 0);
        check("R1 bus_err", 32'(bus_err), 0);
        for (int a = 0; a < 5; a++) begin
            rd_reg(3'(a), d, e);
            check("R1 register word", d, 0);
        end

        // R3 mask write and readback
        wr_reg(3'd0, 32'hFFFF_FFFF, e);
        check("R3 write err", 32'(e), 0);
        rd_reg(3'd0, d, e);
        check("R3 mask readback", d, 32'h3FFF_FFFF);

        // R5/R2/R4 single line sweep with full mask
        for (int i = 0; i < N; i++) begin
            irq_i = N'(1) << i;
            tick();
            check("R5 single vec", 32'(hard_vec), 32'(8'h31 + 8'(i)));
            check("R5 single req", 32'(hard_req), 1);
            rd_reg(3'd1, d, e);
            check("R2 raw pending", d, 32'(N'(1) << i));
            rd_reg(3'd2, d, e);
            check("R4 masked pending", d, 32'(N'(1) << i));
        end

        // R6 pairs sweep
        for (int i = 0; i < N; i++) begin
            irq_i = (N'(1) << i) | (N'(1) << ((i + 7) % N));
            tick();
            check("R6 multi vec", 32'(hard_vec), 32'h30);
            check("R6 multi req", 32'(hard_req), 1);
        end

        // R5/R4 mask sweep with all lines high
        irq_i = '1;
        for (int j = 0; j < N; j++) begin
            m = N'(1) << j;
            wr_reg(3'd0, 32'(m), e);
            check("R5 masked single vec", 32'(hard_vec), 32'(exp_vec(m)));
            rd_reg(3'd2, d, e);
            check("R4 masked value", d, 32'(m));
        end
        wr_reg(3'd0, 32'h0000_F00F, e);
        check("R4 R6 partial mask vec", 32'(hard_vec), 32'(exp_vec(N'(32'h0000_F00F))));
        rd_reg(3'd2, d, e);
        check("R4 partial mask", d, 32'h0000_F00F);

        // R7 zero masked
        wr_reg(3'd0, 32'h0, e);
        check("R7 vec zero by mask", 32'(hard_vec), 0);
        check("R7 req zero by mask", 32'(hard_req), 0);
        wr_reg(3'd0, 32'hFFFF_FFFF, e);
        irq_i = '0;
        tick();
        check("R7 vec zero by inputs", 32'(hard_vec), 0);
        check("R7 req zero by inputs", 32'(hard_req), 0);

        // R11 latency
        irq_i = N'(1) << 5;
        #1;
        check("R11 before edge", 32'(hard_vec), 0);
        tick();
        check("R11 after edge", 32'(hard_vec), 32'h36);
        irq_i = '0;
        tick();

        // R8 non-maskable path, mask cleared
        wr_reg(3'd0, 32'h0, e);
        for (int v = 1; v < 4; v++) begin
            nmi_i = 2'(v);
            tick();
            check("R8 nmi_req", 32'(nmi_req), 1);
            check("R8 hard_req unaffected", 32'(hard_req), 0);
            rd_reg(3'd3, d, e);
            check("R8 nmi status", d, 32'(v));
        end
        nmi_i = 2'b00;
        tick();
        check("R8 nmi_req clear", 32'(nmi_req), 0);

        // R10 illegal reads
        for (int a = 5; a < 8; a++) begin
            rd_reg(3'(a), d, e);
            check("R10 illegal read data", d, 0);
            check("R10 illegal read err", 32'(e), 1);
            check("R10 err one cycle", 32'(bus_err), 1);
            tick();
            check("R10 err drops", 32'(bus_err), 0);
        end
        // R10 illegal writes leave mask unchanged
        wr_reg(3'd0, 32'h0000_1234, e);
        for (int a = 1; a < 8; a++) begin
            wr_reg(3'(a), 32'hFFFF_FFFF, e);
            check("R10 illegal write err", 32'(e), 1);
            rd_reg(3'd0, d, e);
            check("R10 mask unchanged", d, 32'h0000_1234);
            check("R10 err gone after", 32'(e), 0);
        end

        // R9 fault sticky
        check("R9 flag idle", 32'(fault_flag), 0);
        fault_i = 1'b1;
        tick();
        fault_i = 1'b0;
        check("R9 flag set", 32'(fault_flag), 1);
        repeat (4) tick();
        check("R9 flag sticky", 32'(fault_flag), 1);
        rd_reg(3'd4, d, e);
        check("R9 status bit0", d, 1);

        // R1 reset clears everything again
        irq_i = '0;
        do_reset();
        check("R1 fault cleared", 32'(fault_flag), 0);
        rd_reg(3'd0, d, e);
        check("R1 mask cleared", d, 0);
        rd_reg(3'd4, d, e);
        check("R1 fault word cleared", d, 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule